// File: doc/BRIEF.md
# Multi-Channel Timer/Counter Unit with Grouped Interrupts

This block holds a parameterised bank of six or eight timer channels, a watchdog clock slot and a wide OS-timer slot behind one simple word-addressed register port. Every channel owns an up-counter that can run free, act as a periodic timer or drive a PWM output. Each channel chooses its count clock from the core clock, an external clock input or a real-time clock input. It can switch that clock off and divide it by a prescale factor, all from its own control word. The watchdog and OS-timer slots use the same control word layout to form their own count clocks.

One shared gate, written through separate set and clear addresses, starts and stops the count clock of every channel and of the two slots. Channel full-compare matches raise sticky flags. The flags pass through a mask and are combined onto three interrupt lines. Channel 5 has a line to itself. Every other channel shares one line. The OS-timer slot has its own line.

Reads are combinational from the address; a write takes effect at the clock edge on which `wr_en_i` is high. The asynchronous reset is released synchronously through a two-stage synchroniser inside the block.

Top module: `tmr_unit`

## Requirements
- R1: Control field [1:0] selects the count source: 0 = core clock (one source tick per cycle), 1 = rising edges of `ext_clk_i`, 2 = rising edges of `rtc_clk_i`, 3 = no clock. Each rising edge of a slow external or real-time input gives exactly one source tick.
- R2: Control field [4:2] is a prescale code that divides the source ticks by 1, 4, 16, 64, 256 or 1024 for codes 0 to 5. Codes 6 and 7 behave as 1024.
- R3: The gate status reads at 0x00, write-1-to-set is at 0x01 and write-1-to-clear is at 0x02. Bit i gates channel i, bit 8 the watchdog slot and bit 9 the OS-timer slot. A cleared bit stops that count clock, and other bits are untouched by a write.
- R4: Control field [6:5] is the mode: 0 = free (the counter wraps at all ones and does not reload at the full value), 1 = periodic (after the tick that matches the full value the counter becomes 0), 2 = PWM (periodic plus output), 3 = same as periodic.
- R5: In PWM mode, `pwm_o[i]` is high while the channel count is below its half-compare value and low otherwise. In any other mode it is low.
- R6: A count tick at which the counter equals the full value sets sticky flag bit i, read at 0x03. Writing 1 to a bit at 0x04 clears it, and a new match in the same cycle wins over the clear.
- R7: The mask at 0x05 uses 1 = masked. `irq_o[1]` is the unmasked flag of channel 5, `irq_o[0]` is the OR of all other unmasked channel flags, and `irq_o[2]` is the unmasked OS-timer flag (bit 8).
- R8: The watchdog slot control word at 0x06 uses the source and prescale fields of R1 and R2. While gate bit 8 is set, `wdt_tick_o` pulses for one cycle per divided count clock.
- R9: The OS-timer slot (`OST_W` of 32 or 64) has its control word at 0x07, compare at 0x08/0x09 and count at 0x0A/0x0B (low/high word; the high word reads 0 when 32 bits wide). It counts up on its count clock, becomes 0 after the tick that matches compare, and sets flag bit 8 on that tick.
- R10: Channel i occupies 0x10+4i with offsets +0 control, +1 full value, +2 half value and +3 count. Writing the count loads the counter, and a gated channel holds its count.
- R11: After reset the gate, flags, control words, compares and counts read 0, the mask reads 1 for every implemented flag (0x1FF with eight channels), and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, also the core-clock count source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | Slow external count clock, sampled and edge-detected |
| rtc_clk_i | input | 1 | Slow real-time count clock, sampled and edge-detected |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pwm_o | output | NUM_CH | PWM output per channel |
| irq_o | output | 3 | [0] shared channel line, [1] channel 5 line, [2] OS-timer line |
| wdt_tick_o | output | 1 | Divided count clock pulse for the watchdog slot |

## Verification
The prescale is swept over all eight codes with a core-clock source. In each case the count advance over a window of exactly three divide periods must equal three, which tells every divide factor apart and shows that codes 6 and 7 match 1024. Periodic, alternate and PWM modes are run against several full and half values, including zero and values past the full value, and the count is followed cycle by cycle modulo the period. A free-running count is started just below all ones to show the wrap and the absence of a reload at the full value. The external and real-time inputs are driven with counted pulses, each channel in turn is made to match, with its interrupt line checked masked and unmasked, and the OS-timer and watchdog slots are followed through their own gate bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    SRC_PCLK = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_RTC  = 2'd2,
    SRC_OFF  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_PWM      = 2'd2,
    MODE_ALT      = 2'd3
  } mode_e;

  // control word: [6:5] mode, [4:2] prescale code, [1:0] source
  typedef struct packed {
    mode_e      mode;
    logic [2:0] presc;
    src_e       src;
  } clk_ctl_t;

  localparam int CTL_W     = 7;
  localparam int PRESC_W   = 10;
  localparam int PRESC_MAX = 5;

  localparam int A_GATE    = 0;
  localparam int A_GSET    = 1;
  localparam int A_GCLR    = 2;
  localparam int A_FLAG    = 3;
  localparam int A_FCLR    = 4;
  localparam int A_MASK    = 5;
  localparam int A_WCTL    = 6;
  localparam int A_OCTL    = 7;
  localparam int A_OCMPL   = 8;
  localparam int A_OCMPH   = 9;
  localparam int A_OCNTL   = 10;
  localparam int A_OCNTH   = 11;
  localparam int A_CH_BASE = 16;
  localparam int CH_STRIDE = 4;

  localparam int MAX_CH    = 8;
  localparam int DED_CH    = 5;
  localparam int WDT_BIT   = 8;
  localparam int OST_BIT   = 9;
  localparam int GATE_W    = 10;
  localparam int FLAG_W    = 9;
  localparam int OST_FLAG  = 8;

  // terminal value of the prescale counter: 4^code - 1, saturating at code 5
  function automatic logic [PRESC_W-1:0] presc_limit(input logic [2:0] code);
    int unsigned c;
    c = (int'(code) > PRESC_MAX) ? PRESC_MAX : int'(code);
    return PRESC_W'((32'd1 << (2 * c)) - 32'd1);
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] pulse_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [2:0] sh_q;
    logic [2:0] sh_d;

    assign sh_d = {sh_q[1:0], async_i[g]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= sh_d;
    end

    assign pulse_o[g] = sh_q[1] & ~sh_q[2];

    p_one_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[g] |=> !pulse_o[g]);
  end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  src_e       src_i,
  input  logic [2:0] presc_i,
  input  logic       ext_tick_i,
  input  logic       rtc_tick_i,
  output logic       tick_o
);

  logic [PRESC_W-1:0] pcnt_q, pcnt_d;
  logic [PRESC_W-1:0] limit;
  logic               src_tick;
  logic               active;
  logic               at_lim;

  always_comb begin
    unique case (src_i)
      SRC_PCLK: src_tick = 1'b1;
      SRC_EXT:  src_tick = ext_tick_i;
      SRC_RTC:  src_tick = rtc_tick_i;
      default:  src_tick = 1'b0;
    endcase
  end

  assign limit  = presc_limit(presc_i);
  assign active = en_i && (src_i != SRC_OFF);
  assign at_lim = (pcnt_q >= limit);
  assign tick_o = active && src_tick && at_lim;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!active)       pcnt_d = '0;
    else if (src_tick) pcnt_d = at_lim ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end

  // R2: a divided core-clock tick is never followed at once by another
  p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && src_i == SRC_PCLK && presc_i != 3'd0)
      |=> (!tick_o || presc_i == 3'd0 || src_i != SRC_PCLK));

  // R3: a stopped gate yields no tick
  p_gate_stops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] full_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic             wr_cnt_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             pwm_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             match;
  logic             reload;

  assign match  = (cnt_q == full_i);
  assign reload = (mode_i != MODE_FREE);
  assign hit_o  = tick_i && match;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt_i)    cnt_d = wr_val_i;
    else if (tick_i) cnt_d = (reload && match) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign pwm_o = (mode_i == MODE_PWM) && (cnt_q < half_i);

  p_reload_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && tick_i && mode_i != MODE_FREE && cnt_q == full_i) |=> (cnt_q == '0));

  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt_i && !tick_i) |=> $stable(cnt_q));

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> (cnt_q == $past(wr_val_i)));

endmodule

// File: rtl/tmr_ost.sv
module tmr_ost #(
  parameter int OST_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [OST_W-1:0] cmp_i,
  output logic [OST_W-1:0] cnt_o,
  output logic             hit_o
);

  logic [OST_W-1:0] cnt_q, cnt_d;
  logic             match;

  assign match = (cnt_q == cmp_i);
  assign hit_o = tick_i && match;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = match ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_ost_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == cmp_i) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int OST_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              rtc_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [2:0]        irq_o,
  output logic              wdt_tick_o
);

  localparam logic [GATE_W-1:0] GATE_VALID =
    GATE_W'(((1 << NUM_CH) - 1) | (1 << WDT_BIT) | (1 << OST_BIT));
  localparam logic [FLAG_W-1:0] FLAG_VALID =
    FLAG_W'(((1 << NUM_CH) - 1) | (1 << OST_FLAG));
  localparam int IDX_W = ADDR_W - 2;

  // ---------------- reset release ----------------
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // ---------------- address decode ----------------
  logic              wr_gset, wr_gclr, wr_fclr, wr_mask;
  logic              wr_wctl, wr_octl, wr_ocmpl, wr_ocmph;
  logic [ADDR_W-1:0] ch_off;
  logic              in_ch;
  logic [IDX_W-1:0]  ch_idx;
  logic [1:0]        ch_reg;
  logic [NUM_CH-1:0] wr_ch;

  assign wr_gset  = wr_en_i && (addr_i == ADDR_W'(A_GSET));
  assign wr_gclr  = wr_en_i && (addr_i == ADDR_W'(A_GCLR));
  assign wr_fclr  = wr_en_i && (addr_i == ADDR_W'(A_FCLR));
  assign wr_mask  = wr_en_i && (addr_i == ADDR_W'(A_MASK));
  assign wr_wctl  = wr_en_i && (addr_i == ADDR_W'(A_WCTL));
  assign wr_octl  = wr_en_i && (addr_i == ADDR_W'(A_OCTL));
  assign wr_ocmpl = wr_en_i && (addr_i == ADDR_W'(A_OCMPL));
  assign wr_ocmph = wr_en_i && (addr_i == ADDR_W'(A_OCMPH));

  assign ch_off = addr_i - ADDR_W'(A_CH_BASE);
  assign in_ch  = (addr_i >= ADDR_W'(A_CH_BASE)) && (ch_off < ADDR_W'(CH_STRIDE * NUM_CH));
  assign ch_idx = ch_off[ADDR_W-1:2];
  assign ch_reg = ch_off[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wdec
    assign wr_ch[g] = wr_en_i && in_ch && (ch_idx == IDX_W'(g));
  end

  // ---------------- register state ----------------
  logic [GATE_W-1:0]                  gate_q, gate_d;
  logic [FLAG_W-1:0]                  flag_q, flag_d;
  logic [FLAG_W-1:0]                  mask_q, mask_d;
  clk_ctl_t                           wctl_q, wctl_d;
  clk_ctl_t                           octl_q, octl_d;
  logic [31:0]                        ocmp_lo_q, ocmp_lo_d;
  clk_ctl_t [NUM_CH-1:0]              ctl_q, ctl_d;
  logic [NUM_CH-1:0][CNT_W-1:0]       full_q, full_d;
  logic [NUM_CH-1:0][CNT_W-1:0]       half_q, half_d;
  logic [FLAG_W-1:0]                  hit_vec;

  always_comb begin
    gate_d = gate_q;
    if (wr_gset) gate_d = gate_q | (wdata_i[GATE_W-1:0] & GATE_VALID);
    if (wr_gclr) gate_d = gate_q & ~wdata_i[GATE_W-1:0];

    flag_d = flag_q;
    if (wr_fclr) flag_d = flag_q & ~wdata_i[FLAG_W-1:0];
    flag_d = flag_d | hit_vec;

    mask_d    = wr_mask  ? (wdata_i[FLAG_W-1:0] & FLAG_VALID) : mask_q;
    wctl_d    = wr_wctl  ? clk_ctl_t'(wdata_i[CTL_W-1:0])     : wctl_q;
    octl_d    = wr_octl  ? clk_ctl_t'(wdata_i[CTL_W-1:0])     : octl_q;
    ocmp_lo_d = wr_ocmpl ? wdata_i                            : ocmp_lo_q;

    ctl_d  = ctl_q;
    full_d = full_q;
    half_d = half_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (wr_ch[i] && ch_reg == 2'd0) ctl_d[i]  = clk_ctl_t'(wdata_i[CTL_W-1:0]);
      if (wr_ch[i] && ch_reg == 2'd1) full_d[i] = wdata_i[CNT_W-1:0];
      if (wr_ch[i] && ch_reg == 2'd2) half_d[i] = wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      gate_q    <= '0;
      flag_q    <= '0;
      mask_q    <= FLAG_VALID;
      wctl_q    <= '0;
      octl_q    <= '0;
      ocmp_lo_q <= '0;
      ctl_q     <= '0;
      full_q    <= '0;
      half_q    <= '0;
    end else begin
      gate_q    <= gate_d;
      flag_q    <= flag_d;
      mask_q    <= mask_d;
      wctl_q    <= wctl_d;
      octl_q    <= octl_d;
      ocmp_lo_q <= ocmp_lo_d;
      ctl_q     <= ctl_d;
      full_q    <= full_d;
      half_q    <= half_d;
    end
  end

  // ---------------- slow clock inputs ----------------
  logic ext_tick, rtc_tick;
  logic [1:0] slow_pulse;

  tmr_edge_sync #(.N(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i ({rtc_clk_i, ext_clk_i}),
    .pulse_o (slow_pulse)
  );
  assign ext_tick = slow_pulse[0];
  assign rtc_tick = slow_pulse[1];

  // ---------------- channels ----------------
  logic [NUM_CH-1:0]            ch_tick;
  logic [NUM_CH-1:0]            ch_hit;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_clk_sel u_clk (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .en_i       (gate_q[g]),
      .src_i      (ctl_q[g].src),
      .presc_i    (ctl_q[g].presc),
      .ext_tick_i (ext_tick),
      .rtc_tick_i (rtc_tick),
      .tick_o     (ch_tick[g])
    );

    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .tick_i   (ch_tick[g]),
      .mode_i   (ctl_q[g].mode),
      .full_i   (full_q[g]),
      .half_i   (half_q[g]),
      .wr_cnt_i (wr_ch[g] && ch_reg == 2'd3),
      .wr_val_i (wdata_i[CNT_W-1:0]),
      .cnt_o    (ch_cnt[g]),
      .hit_o    (ch_hit[g]),
      .pwm_o    (pwm_o[g])
    );
  end

  // ---------------- watchdog slot ----------------
  tmr_clk_sel u_wdt_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (gate_q[WDT_BIT]),
    .src_i      (wctl_q.src),
    .presc_i    (wctl_q.presc),
    .ext_tick_i (ext_tick),
    .rtc_tick_i (rtc_tick),
    .tick_o     (wdt_tick_o)
  );

  // ---------------- OS-timer slot ----------------
  logic             ost_tick, ost_hit;
  logic [OST_W-1:0] ost_cnt, ost_cmp;
  logic [31:0]      ost_cmp_hi_rd, ost_cnt_hi_rd;

  if (OST_W > 32) begin : g_ost_wide
    logic [OST_W-33:0] ocmp_hi_q, ocmp_hi_d;
    assign ocmp_hi_d = wr_ocmph ? wdata_i[OST_W-33:0] : ocmp_hi_q;
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) ocmp_hi_q <= '0;
      else        ocmp_hi_q <= ocmp_hi_d;
    end
    assign ost_cmp       = {ocmp_hi_q, ocmp_lo_q};
    assign ost_cmp_hi_rd = 32'(ocmp_hi_q);
    assign ost_cnt_hi_rd = 32'(ost_cnt[OST_W-1:32]);
  end else begin : g_ost_narrow
    assign ost_cmp       = ocmp_lo_q[OST_W-1:0];
    assign ost_cmp_hi_rd = '0;
    assign ost_cnt_hi_rd = '0;
  end

  tmr_clk_sel u_ost_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (gate_q[OST_BIT]),
    .src_i      (octl_q.src),
    .presc_i    (octl_q.presc),
    .ext_tick_i (ext_tick),
    .rtc_tick_i (rtc_tick),
    .tick_o     (ost_tick)
  );

  tmr_ost #(.OST_W(OST_W)) u_ost (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (ost_tick),
    .cmp_i  (ost_cmp),
    .cnt_o  (ost_cnt),
    .hit_o  (ost_hit)
  );

  // ---------------- interrupt grouping ----------------
  logic [FLAG_W-1:0] pend;

  assign hit_vec = FLAG_W'(ch_hit) | (FLAG_W'(ost_hit) << OST_FLAG);
  assign pend    = flag_q & ~mask_q;

  always_comb begin
    irq_o[0] = 1'b0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i != DED_CH) irq_o[0] = irq_o[0] | pend[i];
    end
    irq_o[1] = pend[DED_CH];
    irq_o[2] = pend[OST_FLAG];
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_GATE):  rdata_o = 32'(gate_q);
      ADDR_W'(A_FLAG):  rdata_o = 32'(flag_q);
      ADDR_W'(A_MASK):  rdata_o = 32'(mask_q);
      ADDR_W'(A_WCTL):  rdata_o = 32'(wctl_q);
      ADDR_W'(A_OCTL):  rdata_o = 32'(octl_q);
      ADDR_W'(A_OCMPL): rdata_o = ocmp_lo_q;
      ADDR_W'(A_OCMPH): rdata_o = ost_cmp_hi_rd;
      ADDR_W'(A_OCNTL): rdata_o = ost_cnt[31:0];
      ADDR_W'(A_OCNTH): rdata_o = ost_cnt_hi_rd;
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (in_ch && ch_idx == IDX_W'(i)) begin
            unique case (ch_reg)
              2'd0:    rdata_o = 32'(ctl_q[i]);
              2'd1:    rdata_o = 32'(full_q[i]);
              2'd2:    rdata_o = 32'(half_q[i]);
              default: rdata_o = 32'(ch_cnt[i]);
            endcase
          end
        end
      end
    endcase
  end

  // ---------------- assertions ----------------
  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_fclr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_gate_set_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_gset |=> ((gate_q & $past(wdata_i[GATE_W-1:0] & GATE_VALID))
                 == $past(wdata_i[GATE_W-1:0] & GATE_VALID)));

  p_ded_line_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o[1] |-> (flag_q[DED_CH] && !mask_q[DED_CH]));

endmodule

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        rtc_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pwm;
  logic [2:0]  irq;
  logic        wdt_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_unit dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_clk_i  (ext_clk),
    .rtc_clk_i  (rtc_clk),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .pwm_o      (pwm),
    .irq_o      (irq),
    .wdt_tick_o (wdt_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[7:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = a[7:0];
    #1;
    v = int'(rdata);
  endtask

  function automatic int ch_adr(input int ch, input int off);
    return 16 + 4 * ch + off;
  endfunction

  task automatic quiet();
    wr(2, 32'h3FF);
    wr(4, 32'h1FF);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, c0, c1, prev, cnt;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R11: reset state
    rd(0, v);  check("R11 gate", v, 0);
    rd(3, v);  check("R11 flags", v, 0);
    rd(5, v);  check("R11 mask", v, 32'h1FF);
    rd(ch_adr(0, 0), v); check("R11 ctl", v, 0);
    rd(10, v); check("R11 ost count", v, 0);
    check("R11 outputs", {21'd0, pwm, irq, wdt_tick}, 0);

    // R3: set/clear act bitwise
    wr(1, 32'h005); wr(1, 32'h300);
    rd(0, v); check("R3 set", v, 32'h305);
    wr(2, 32'h101);
    rd(0, v); check("R3 clear", v, 32'h204);
    quiet();

    // R2: prescale sweep on channel 2, window of three divide periods
    wr(ch_adr(2, 1), 32'hFFFF);
    wr(1, 32'h004);
    for (int code = 0; code < 8; code++) begin
      int d;
      d = 1 << (2 * ((code > 5) ? 5 : code));
      wr(ch_adr(2, 0), 32'h20 | (code << 2));
      cyc(d + 2);
      rd(ch_adr(2, 3), c0);
      cyc(3 * d);
      rd(ch_adr(2, 3), c1);
      check($sformatf("R2 code %0d", code), (c1 - c0) & 32'hFFFF, 3);
    end

    // R3: gated channel holds; R1: source code 3 holds
    wr(2, 32'h004);
    rd(ch_adr(2, 3), c0); cyc(20); rd(ch_adr(2, 3), c1);
    check("R3 gated hold", c1, c0);
    wr(ch_adr(2, 0), 32'h23); wr(1, 32'h004);
    rd(ch_adr(2, 3), c0); cyc(20); rd(ch_adr(2, 3), c1);
    check("R1 no-clock source", c1, c0);
    quiet();

    // R1: external and real-time sources, one tick per rising edge
    wr(ch_adr(3, 1), 32'hFFFF); wr(ch_adr(3, 0), 32'h21);
    wr(ch_adr(4, 1), 32'hFFFF); wr(ch_adr(4, 0), 32'h22);
    wr(1, 32'h018);
    rd(ch_adr(3, 3), c0); rd(ch_adr(4, 3), prev);
    repeat (5) begin ext_clk = 1'b1; cyc(3); ext_clk = 1'b0; cyc(3); end
    cyc(6);
    rd(ch_adr(3, 3), c1); check("R1 ext edges", c1 - c0, 5);
    rd(ch_adr(4, 3), v);  check("R1 rtc ignores ext", v - prev, 0);
    repeat (7) begin rtc_clk = 1'b1; cyc(3); rtc_clk = 1'b0; cyc(3); end
    cyc(6);
    rd(ch_adr(4, 3), v);  check("R1 rtc edges", v - prev, 7);
    // R2 on the external source: divide by 4
    wr(ch_adr(3, 0), 32'h25);
    rd(ch_adr(3, 3), c0);
    repeat (8) begin ext_clk = 1'b1; cyc(3); ext_clk = 1'b0; cyc(3); end
    cyc(6);
    rd(ch_adr(3, 3), c1); check("R2 ext divide 4", c1 - c0, 2);
    quiet();

    // R4: periodic reload, cycle by cycle, several full values and modes
    for (int k = 0; k < 6; k++) begin
      int f, m;
      f = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : (k == 4) ? 9 : 3;
      m = (k == 5) ? 32'h60 : 32'h20;
      wr(2, 32'h002);
      wr(ch_adr(1, 0), m); wr(ch_adr(1, 1), f); wr(ch_adr(1, 3), 0);
      wr(1, 32'h002);
      rd(ch_adr(1, 3), prev);
      for (int s = 0; s < 3 * (f + 1) + 2; s++) begin
        @(negedge clk);
        rd(ch_adr(1, 3), v);
        check($sformatf("R4 reload full=%0d", f), v, (prev + 1) % (f + 1));
        check("R5 pwm low outside PWM mode", int'(pwm[1]), 0);
        prev = v;
      end
    end
    quiet();

    // R5: PWM output against several half values
    for (int h = 0; h < 7; h++) begin
      wr(2, 32'h002);
      wr(ch_adr(1, 0), 32'h40); wr(ch_adr(1, 1), 4);
      wr(ch_adr(1, 2), h); wr(ch_adr(1, 3), 0);
      wr(1, 32'h002);
      for (int s = 0; s < 12; s++) begin
        rd(ch_adr(1, 3), v);
        check($sformatf("R5 pwm half=%0d cnt=%0d", h, v), int'(pwm[1]), (v < h) ? 1 : 0);
        @(negedge clk);
      end
    end
    quiet();

    // R4 free mode: wraps at all ones, passes the full value without reload
    wr(ch_adr(0, 0), 32'h00); wr(ch_adr(0, 1), 3); wr(ch_adr(0, 3), 32'hFFFC);
    wr(1, 32'h001);
    rd(ch_adr(0, 3), prev);
    for (int s = 0; s < 10; s++) begin
      @(negedge clk);
      rd(ch_adr(0, 3), v);
      check("R4 free run", v, (prev + 1) & 32'hFFFF);
      prev = v;
    end
    wr(2, 32'h001);
    rd(3, v); check("R6 flag on free pass", v & 1, 1);

    // R10: load count on a gated channel
    wr(ch_adr(0, 3), 32'h1234);
    cyc(5);
    rd(ch_adr(0, 3), v); check("R10 count load", v, 32'h1234);
    quiet();

    // R6 / R7: every channel in turn
    for (int ch = 0; ch < 8; ch++) begin
      int exp_irq;
      exp_irq = (ch == 5) ? 2 : 1;
      quiet();
      wr(5, 0);
      wr(ch_adr(ch, 0), 32'h20); wr(ch_adr(ch, 1), 0); wr(ch_adr(ch, 3), 0);
      wr(1, 1 << ch);
      cyc(3);
      wr(2, 1 << ch);
      rd(3, v); check($sformatf("R6 flag ch%0d", ch), v, 1 << ch);
      check($sformatf("R7 line ch%0d", ch), int'(irq), exp_irq);
      wr(5, 1 << ch);
      check($sformatf("R7 masked ch%0d", ch), int'(irq), 0);
      rd(3, v); check("R6 flag kept while masked", v, 1 << ch);
      wr(5, 0);
      wr(4, 1 << ch);
      rd(3, v); check("R6 flag clear", v, 0);
      check("R7 line after clear", int'(irq), 0);
    end
    quiet();

    // R9: OS-timer slot
    wr(7, 0); wr(8, 4); wr(5, 0);
    wr(1, 32'h200);
    rd(10, prev);
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      rd(10, v);
      check("R9 ost count", v, (prev + 1) % 5);
      prev = v;
    end
    wr(2, 32'h200);
    rd(3, v);  check("R9 ost flag", v, 32'h100);
    check("R7 ost line", int'(irq), 4);
    rd(11, v); check("R9 high word", v, 0);
    quiet();

    // R8: watchdog slot, divide by 4
    wr(6, 32'h04);
    wr(1, 32'h100);
    cyc(10);
    cnt = 0;
    for (int s = 0; s < 40; s++) begin
      if (wdt_tick) cnt++;
      @(negedge clk);
    end
    check("R8 wdt ticks", cnt, 10);
    wr(2, 32'h100);
    cnt = 0;
    for (int s = 0; s < 20; s++) begin
      if (wdt_tick) cnt++;
      @(negedge clk);
    end
    check("R8 wdt gated", cnt, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule